// File: doc/BRIEF.md
# Sign-Extending Move Execution Unit

This unit executes the register-destination form of a sign-extending move for a prefixed, variable-length instruction set. Each transaction brings the opcode bytes, the prefix state, the processor mode, the ModRM byte, the source value (a register-file read or a memory load) and the old contents of the destination register. From these the unit works out the source and destination widths. It copies the top bit of the source into every higher bit of the destination width and merges the result into the destination register image. The result is one write-back record: a write enable, a 4-bit register index, 64-bit data, and an invalid-opcode flag.

The unit also drives a combinational source-register index. This index is derived from the ModRM and prefix inputs in the same cycle, so the register file upstream can read the right register, including the legacy high-byte registers. Memory addressing, segment and paging checks, and the register file itself are not part of this unit.

Both data interfaces use valid/ready. An input is taken on a clock edge where `in_valid` and `in_ready` are both high. A result is handed on at an edge where `out_valid` and `out_ready` are both high. `in_ready` is high whenever the output stage is empty or is being drained in that cycle. While `out_valid` is high and `out_ready` is low, the result stays on the outputs without change, and no new input is taken.

Top module: `sxmov_unit`

## Requirements
- R1: Source width comes from the opcode. With `in_esc`=1, opcode 0xBE gives 8 bits and 0xBF gives 16 bits. With `in_esc`=0 and `in_long_mode`=1, opcode 0x63 gives 32 bits.
- R2: Destination width in 64-bit mode is 64 when REX.W is set, otherwise 16 when the operand-size override is set, otherwise 32. Outside 64-bit mode it is 32 when `in_def32` XOR `in_opsz` is 1, and 16 otherwise.
- R3: The result is the source value, sign-extended to the destination width. When the destination is narrower than the source, the result is the source truncated to the destination width.
- R4: A 16-bit write keeps bits 63:16 of `in_dst_old`. A 32-bit write clears bits 63:32. A 64-bit write replaces all bits.
- R5: Any transaction with `in_lock`=1 produces `out_ud`=1 and `out_wr_en`=0.
- R6: An opcode not listed in R1, opcode 0x63 outside 64-bit mode, and a REX prefix outside 64-bit mode each produce `out_ud`=1 and `out_wr_en`=0.
- R7: For an 8-bit register source (ModRM mod=3) with no REX prefix, r/m codes 4 to 7 read bits 15:8 of registers 0 to 3, and `src_rd_idx` is r/m minus 4. With any REX prefix, those codes read bits 7:0 of the register named by the code.
- R8: `out_wr_idx` is {REX.R, ModRM reg}. Otherwise `src_rd_idx` is {REX.B AND 64-bit mode, ModRM r/m}. A memory source (mod not 3) always takes bits 7:0 as the byte.
- R9: An accepted input appears on the outputs one clock later with `out_valid`=1. The outputs hold steady while `out_ready`=0. `in_ready` equals NOT `out_valid` OR `out_ready`.
- R10: During and right after reset, `out_valid`=0 and `in_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input transaction present |
| in_ready | output | 1 | Unit can take an input this cycle |
| in_esc | input | 1 | Two-byte opcode escape (0x0F) present |
| in_opcode | input | 8 | Final opcode byte |
| in_modrm | input | 8 | ModRM byte |
| in_rex | input | 1 | A REX prefix is present |
| in_rex_w | input | 1 | REX.W |
| in_rex_r | input | 1 | REX.R |
| in_rex_b | input | 1 | REX.B |
| in_opsz | input | 1 | Operand-size override prefix present |
| in_lock | input | 1 | LOCK prefix present |
| in_long_mode | input | 1 | Processor is in 64-bit mode |
| in_def32 | input | 1 | Default operand size is 32 (outside 64-bit mode) |
| in_src_data | input | 64 | Source register contents or loaded memory data |
| in_dst_old | input | 64 | Current contents of the destination register |
| src_rd_idx | output | 4 | Combinational register-file read index for the source |
| out_valid | output | 1 | Write-back record present |
| out_ready | input | 1 | Consumer takes the record this cycle |
| out_wr_en | output | 1 | Register write enable |
| out_wr_idx | output | 4 | Destination register index |
| out_wr_data | output | 64 | Merged 64-bit destination value |
| out_ud | output | 1 | Invalid-opcode exception |

## Verification
`src_rd_idx` is combinational, so it is checked in the same cycle that the inputs are driven, a short delay after the falling edge. Every write-back field passes through exactly one register. A record accepted at a rising edge is therefore checked at the next falling edge, and it is checked again at each later falling edge for as long as `out_ready` holds it. The bench's model steps in time with this. At each falling edge it first compares the record it predicts for the current output stage, then drives new inputs. It then predicts, from the handshake at the coming edge, whether that record is loaded, kept or drained.

// File: rtl/sxm_pkg.sv
package sxm_pkg;
  parameter int XLEN  = 64;
  parameter int IDX_W = 4;

  localparam logic [7:0] OPC_SX_BYTE = 8'hBE;
  localparam logic [7:0] OPC_SX_HALF = 8'hBF;
  localparam logic [7:0] OPC_SX_WORD = 8'h63;

  typedef enum logic [1:0] {
    SZ_8  = 2'd0,
    SZ_16 = 2'd1,
    SZ_32 = 2'd2,
    SZ_64 = 2'd3
  } sz_e;

  typedef struct packed {
    logic             we;
    logic             ud;
    logic [IDX_W-1:0] idx;
    logic [XLEN-1:0]  data;
  } wb_t;
endpackage

// File: rtl/sxm_decode.sv
module sxm_decode
  import sxm_pkg::*;
(
  input  logic             esc,
  input  logic [7:0]       opcode,
  input  logic [7:0]       modrm,
  input  logic             rex,
  input  logic             rex_w,
  input  logic             rex_r,
  input  logic             rex_b,
  input  logic             opsz,
  input  logic             lock,
  input  logic             long_mode,
  input  logic             def32,
  output sz_e              src_sz,
  output sz_e              dst_sz,
  output logic             hi_byte,
  output logic             fault,
  output logic [IDX_W-1:0] src_idx,
  output logic [IDX_W-1:0] dst_idx
);
  localparam int FIELD_W = 3;

  logic                known;
  logic                byte_src;
  logic                reg_src;
  logic [FIELD_W-1:0]  rm_f;
  logic [FIELD_W-1:0]  reg_f;

  assign rm_f    = modrm[FIELD_W-1:0];
  assign reg_f   = modrm[2*FIELD_W-1:FIELD_W];
  assign reg_src = (modrm[7:6] == 2'b11);

  // opcode classes and source width
  always_comb begin
    known    = 1'b0;
    src_sz   = SZ_8;
    byte_src = 1'b0;
    if (esc && opcode == OPC_SX_BYTE) begin
      known    = 1'b1;
      src_sz   = SZ_8;
      byte_src = 1'b1;
    end else if (esc && opcode == OPC_SX_HALF) begin
      known  = 1'b1;
      src_sz = SZ_16;
    end else if (!esc && opcode == OPC_SX_WORD && long_mode) begin
      known  = 1'b1;
      src_sz = SZ_32;
    end
  end

  // effective operand size
  always_comb begin
    if (long_mode) begin
      if (rex_w)     dst_sz = SZ_64;
      else if (opsz) dst_sz = SZ_16;
      else           dst_sz = SZ_32;
    end else begin
      dst_sz = (def32 ^ opsz) ? SZ_32 : SZ_16;
    end
  end

  assign fault = !known || lock || (rex && !long_mode);

  // legacy high-byte registers only without any REX prefix
  assign hi_byte = byte_src && reg_src && !rex && rm_f[FIELD_W-1];

  assign src_idx = hi_byte ? {{(IDX_W-FIELD_W+1){1'b0}}, rm_f[FIELD_W-2:0]}
                           : {rex_b & long_mode, rm_f};
  assign dst_idx = {rex_r & long_mode, reg_f};
endmodule

// File: rtl/sxm_extend.sv
module sxm_extend
  import sxm_pkg::*;
(
  input  sz_e             src_sz,
  input  sz_e             dst_sz,
  input  logic            hi_byte,
  input  logic [XLEN-1:0] src_data,
  input  logic [XLEN-1:0] dst_old,
  output logic [XLEN-1:0] wr_data
);
  localparam int BYTE_W = 8;
  localparam int HALF_W = 16;
  localparam int WORD_W = 32;

  logic [XLEN-1:0] raw;
  logic [XLEN-1:0] ext;
  logic [XLEN-1:0] sized;
  logic [XLEN-1:0] keep_mask;

  assign raw = hi_byte ? (src_data >> BYTE_W) : src_data;

  always_comb begin
    case (src_sz)
      SZ_8:    ext = {{(XLEN-BYTE_W){raw[BYTE_W-1]}}, raw[BYTE_W-1:0]};
      SZ_16:   ext = {{(XLEN-HALF_W){raw[HALF_W-1]}}, raw[HALF_W-1:0]};
      SZ_32:   ext = {{(XLEN-WORD_W){raw[WORD_W-1]}}, raw[WORD_W-1:0]};
      default: ext = raw;
    endcase
  end

  // destination-width shaping: 16 keeps upper bits, 32 clears them
  always_comb begin
    case (dst_sz)
      SZ_16: begin
        sized     = {{(XLEN-HALF_W){1'b0}}, ext[HALF_W-1:0]};
        keep_mask = {{(XLEN-HALF_W){1'b1}}, {HALF_W{1'b0}}};
      end
      SZ_32: begin
        sized     = {{(XLEN-WORD_W){1'b0}}, ext[WORD_W-1:0]};
        keep_mask = '0;
      end
      default: begin
        sized     = ext;
        keep_mask = '0;
      end
    endcase
  end

  assign wr_data = (dst_old & keep_mask) | sized;
endmodule

// File: rtl/sxm_stage.sv
module sxm_stage #(
  parameter int PAY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             up_valid,
  output logic             up_ready,
  input  logic [PAY_W-1:0] up_data,
  output logic             dn_valid,
  input  logic             dn_ready,
  output logic [PAY_W-1:0] dn_data
);
  logic             full;
  logic [PAY_W-1:0] store;

  assign up_ready = !full || dn_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full <= 1'b0;
    end else if (up_ready) begin
      full <= up_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (up_valid && up_ready) begin
      store <= up_data;
    end
  end

  assign dn_valid = full;
  assign dn_data  = store;
endmodule

// File: rtl/sxmov_unit.sv
module sxmov_unit
  import sxm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_esc,
  input  logic [7:0]       in_opcode,
  input  logic [7:0]       in_modrm,
  input  logic             in_rex,
  input  logic             in_rex_w,
  input  logic             in_rex_r,
  input  logic             in_rex_b,
  input  logic             in_opsz,
  input  logic             in_lock,
  input  logic             in_long_mode,
  input  logic             in_def32,
  input  logic [XLEN-1:0]  in_src_data,
  input  logic [XLEN-1:0]  in_dst_old,
  output logic [IDX_W-1:0] src_rd_idx,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             out_wr_en,
  output logic [IDX_W-1:0] out_wr_idx,
  output logic [XLEN-1:0]  out_wr_data,
  output logic             out_ud
);
  localparam int PAY_W = $bits(wb_t);

  sz_e              src_sz;
  sz_e              dst_sz;
  logic             hi_byte;
  logic             fault;
  logic [IDX_W-1:0] dst_idx;
  logic [XLEN-1:0]  merged;
  wb_t              wb_in;
  wb_t              wb_out;
  logic [PAY_W-1:0] wb_bits;

  sxm_decode u_decode (
    .esc       (in_esc),
    .opcode    (in_opcode),
    .modrm     (in_modrm),
    .rex       (in_rex),
    .rex_w     (in_rex_w),
    .rex_r     (in_rex_r),
    .rex_b     (in_rex_b),
    .opsz      (in_opsz),
    .lock      (in_lock),
    .long_mode (in_long_mode),
    .def32     (in_def32),
    .src_sz    (src_sz),
    .dst_sz    (dst_sz),
    .hi_byte   (hi_byte),
    .fault     (fault),
    .src_idx   (src_rd_idx),
    .dst_idx   (dst_idx)
  );

  sxm_extend u_extend (
    .src_sz   (src_sz),
    .dst_sz   (dst_sz),
    .hi_byte  (hi_byte),
    .src_data (in_src_data),
    .dst_old  (in_dst_old),
    .wr_data  (merged)
  );

  always_comb begin
    wb_in.we   = !fault;
    wb_in.ud   = fault;
    wb_in.idx  = fault ? '0 : dst_idx;
    wb_in.data = fault ? '0 : merged;
  end

  sxm_stage #(.PAY_W(PAY_W)) u_stage (
    .clk      (clk),
    .rst_n    (rst_n),
    .up_valid (in_valid),
    .up_ready (in_ready),
    .up_data  (wb_in),
    .dn_valid (out_valid),
    .dn_ready (out_ready),
    .dn_data  (wb_bits)
  );

  assign wb_out      = wb_t'(wb_bits);
  assign out_wr_en   = out_valid && wb_out.we;
  assign out_ud      = out_valid && wb_out.ud;
  assign out_wr_idx  = wb_out.idx;
  assign out_wr_data = wb_out.data;
endmodule

// File: rtl/sxmov_unit_chk.sv
module sxmov_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic        in_rex,
  input logic        in_lock,
  input logic        in_long_mode,
  input logic        out_valid,
  input logic        out_ready,
  input logic        out_wr_en,
  input logic [3:0]  out_wr_idx,
  input logic [63:0] out_wr_data,
  input logic        out_ud
);
  p_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_wr_data) &&
      $stable(out_wr_idx) && $stable(out_wr_en) && $stable(out_ud));

  p_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  p_lock_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_lock |=> out_ud && !out_wr_en);

  p_rex_legacy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_rex && !in_long_mode |=> out_ud);

  p_fault_nowrite_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_ud |-> !out_wr_en);
endmodule

bind sxmov_unit sxmov_unit_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid     (in_valid),
  .in_ready     (in_ready),
  .in_rex       (in_rex),
  .in_lock      (in_lock),
  .in_long_mode (in_long_mode),
  .out_valid    (out_valid),
  .out_ready    (out_ready),
  .out_wr_en    (out_wr_en),
  .out_wr_idx   (out_wr_idx),
  .out_wr_data  (out_wr_data),
  .out_ud       (out_ud)
);

// File: tb/test_sxmov_unit.sv
`timescale 1ns/1ps
module test_sxmov_unit;
  localparam int NCYC = 4000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_ready;
  logic        in_esc;
  logic [7:0]  in_opcode, in_modrm;
  logic        in_rex, in_rex_w, in_rex_r, in_rex_b;
  logic        in_opsz, in_lock, in_long_mode, in_def32;
  logic [63:0] in_src_data, in_dst_old;
  logic [3:0]  src_rd_idx;
  logic        out_valid, out_ready, out_wr_en, out_ud;
  logic [3:0]  out_wr_idx;
  logic [63:0] out_wr_data;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sxmov_unit i_sxmov_unit (.*);

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // model state: record held in the output stage
  bit          m_valid;
  bit          m_we, m_ud;
  bit [3:0]    m_idx;
  bit [63:0]   m_data;
  string       m_tag;

  function automatic bit is_hi();
    return in_esc && in_opcode == 8'hBE && in_modrm[7:6] == 2'b11 &&
           !in_rex && in_modrm[2];
  endfunction

  function automatic bit [3:0] exp_src_idx();
    if (is_hi()) return {2'b00, in_modrm[1:0]};
    return {in_rex_b && in_long_mode, in_modrm[2:0]};
  endfunction

  task automatic predict();
    int sw, dw;
    logic [63:0] raw, t;
    bit known;
    known = 1;
    if (in_esc && in_opcode == 8'hBE) sw = 8;
    else if (in_esc && in_opcode == 8'hBF) sw = 16;
    else if (!in_esc && in_opcode == 8'h63 && in_long_mode) sw = 32;
    else begin sw = 8; known = 0; end
    if (in_long_mode) dw = in_rex_w ? 64 : (in_opsz ? 16 : 32);
    else dw = (in_def32 != in_opsz) ? 32 : 16;
    m_ud = !known || in_lock || (in_rex && !in_long_mode);
    m_we = !m_ud;
    m_idx = {in_rex_r, in_modrm[5:3]};
    raw = is_hi() ? (in_src_data >> 8) : in_src_data;
    t = raw << (64 - sw);
    t = $signed(t) >>> (64 - sw);
    if (dw == 64) m_data = t;
    else if (dw == 32) m_data = {32'h0, t[31:0]};
    else m_data = {in_dst_old[63:16], t[15:0]};
    if (in_lock) m_tag = "R5";
    else if (m_ud) m_tag = "R6";
    else if (is_hi()) m_tag = "R7";
    else if (dw == 16) m_tag = "R4";
    else if (sw == 32) m_tag = "R1";
    else m_tag = "R3";
  endtask

  task automatic set_op(bit esc, logic [7:0] opc, logic [7:0] mrm, bit lm);
    in_valid = 1; in_esc = esc; in_opcode = opc; in_modrm = mrm;
    in_long_mode = lm; in_rex = 0; in_rex_w = 0; in_rex_r = 0; in_rex_b = 0;
    in_opsz = 0; in_lock = 0; in_def32 = 1; out_ready = 1;
    in_src_data = 64'h0123_4567_89AB_CDEF; in_dst_old = 64'hAAAA_BBBB_CCCC_DDDD;
  endtask

  task automatic drive(int cyc);
    int r;
    case (cyc)
      0: begin set_op(1, 8'hBE, 8'hC0, 1); in_src_data = 64'h80; end        // R3 negative byte
      1: begin set_op(1, 8'hBE, 8'hC4, 1); in_src_data = 64'h81FF; end      // R7 high byte
      2: begin set_op(1, 8'hBE, 8'hC4, 1); in_rex = 1; in_src_data = 64'h817F; end // R7 with REX
      3: begin set_op(1, 8'hBF, 8'hD9, 1); in_opsz = 1; in_src_data = 64'h8001; end // R2 R4
      4: begin set_op(0, 8'h63, 8'hC1, 1); in_rex = 1; in_rex_w = 1; in_rex_r = 1;
               in_src_data = 64'hFFFF_FFFF_9000_0000; end                  // R1 R8
      5: begin set_op(1, 8'hBF, 8'hC1, 1); in_lock = 1; end                 // R5
      6: begin set_op(0, 8'h63, 8'hC1, 0); end                              // R6 legacy mode
      7: begin set_op(1, 8'hBE, 8'hC0, 1); out_ready = 0; end               // R9 stall
      8: begin set_op(1, 8'hBE, 8'hC1, 1); out_ready = 0; end               // R9 stall
      default: begin
        in_valid = ($urandom % 5) != 0;
        out_ready = ($urandom % 10) < 7;
        r = $urandom % 8;
        if (r < 3)      begin in_esc = 1; in_opcode = 8'hBE; end
        else if (r < 5) begin in_esc = 1; in_opcode = 8'hBF; end
        else if (r < 7) begin in_esc = 0; in_opcode = 8'h63; end
        else begin in_esc = $urandom % 2; in_opcode = 8'($urandom); end
        in_modrm = 8'($urandom);
        in_long_mode = ($urandom % 4) != 0;
        in_rex = in_long_mode ? ($urandom % 2) : (($urandom % 16) == 0);
        in_rex_w = in_rex && ($urandom % 2);
        in_rex_r = in_rex && ($urandom % 2);
        in_rex_b = in_rex && ($urandom % 2);
        in_opsz = $urandom % 3 == 0;
        in_lock = $urandom % 16 == 0;
        in_def32 = $urandom % 2;
        in_src_data = {$urandom, $urandom};
        in_dst_old = {$urandom, $urandom};
      end
    endcase
  endtask

  initial begin
    rst_n = 0;
    set_op(1, 8'hBE, 8'hC0, 1);
    in_valid = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10 reset state
    chk(out_valid === 1'b0, "R10 out_valid", 64'(out_valid), 0);
    chk(in_ready === 1'b1, "R10 in_ready", 64'(in_ready), 1);
    rst_n = 1;
    m_valid = 0;
    for (int cyc = 0; cyc < NCYC; cyc++) begin
      @(negedge clk);
      chk(out_valid === m_valid, "R9 out_valid", 64'(out_valid), 64'(m_valid));
      if (m_valid) begin
        chk(out_ud === m_ud, {m_tag, " out_ud"}, 64'(out_ud), 64'(m_ud));
        chk(out_wr_en === m_we, {m_tag, " out_wr_en"}, 64'(out_wr_en), 64'(m_we));
        if (m_we) begin
          chk(out_wr_idx === m_idx, "R8 out_wr_idx", 64'(out_wr_idx), 64'(m_idx));
          chk(out_wr_data === m_data, {m_tag, " out_wr_data"}, out_wr_data, m_data);
        end
      end
      drive(cyc);
      #1;
      chk(src_rd_idx === exp_src_idx(), is_hi() ? "R7 src_rd_idx" : "R8 src_rd_idx",
          64'(src_rd_idx), 64'(exp_src_idx()));
      chk(in_ready === (!m_valid || out_ready), "R9 in_ready",
          64'(in_ready), 64'(!m_valid || out_ready));
      if (in_valid && (!m_valid || out_ready)) begin
        predict();
        m_valid = 1;
      end else if (out_ready) begin
        m_valid = 0;
      end
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end
endmodule